// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Index Scheduler

This block walks the in-place, iterative radix-2 FFT for a transform of power-of-two length and emits one butterfly per handshake. Each butterfly gives the two element indices, the twiddle exponent on the full-size scale, the stage it belongs to, and flags that mark the last butterfly of a stage and of the whole transform. The downstream datapath forms x[upper] + W^k·x[lower] into the upper slot and x[upper] − W^k·x[lower] into the lower slot, with W = exp(−2πi/size). The scheduler does no arithmetic and generates no twiddle values. Its only job is the sequence of indices, so one vector operation can be remapped over every stage.

A run begins with a one-cycle start strobe that carries the size. A size that is not a power of two and is above 1 raises an error flag and produces no schedule. Sizes 0 and 1 finish at once, with no butterflies and no error. The schedule advances one butterfly on each cycle in which valid and ready are both high.

Top module: `fft_bfly_sched`

## Requirements
- R1: A start with a size above 1 that is not a power of two (this includes 3, 12 and 96) sets err in the next cycle and leaves valid low. The next start with an acceptable size clears err.
- R2: A start with size 0 or 1 produces no butterflies. valid and err both stay low.
- R3: For stage s (span 2^(s+1)), idxLower equals idxUpper + 2^s, and bit s of idxUpper is 0.
- R4: twiddle equals (idxUpper mod 2^s) · size / 2^(s+1). In stage 0 it is always 0.
- R5: Stages are emitted in order from 0 to log2(size)−1. Each stage has size/2 butterflies, in strictly ascending idxUpper order. valid drops after the last butterfly.
- R6: lastStage is high only on the final butterfly of each stage. lastAll is high only on the final butterfly of the final stage.
- R7: While valid is high and ready is low, every output holds its value. The schedule advances on each cycle in which valid and ready are both high.
- R8: A start while a schedule is running is ignored. The running schedule continues unchanged and err is not updated.
- R9: After reset, valid, err, lastStage and lastAll are low.
- R10: The first butterfly (indices 0 and 1, twiddle 0, stage 0) is on the outputs in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a schedule |
| sizeIn | input | 7 | Transform size, sampled with start |
| ready | input | 1 | Downstream accepts the current butterfly |
| valid | output | 1 | A butterfly is presented |
| idxUpper | output | 6 | Index of the element that receives the sum |
| idxLower | output | 6 | Index of the element that receives the difference |
| twiddle | output | 6 | Twiddle exponent on the full-size scale |
| stageIdx | output | 3 | Stage number, 0 for span 2 |
| lastStage | output | 1 | Final butterfly of the current stage |
| lastAll | output | 1 | Final butterfly of the transform |
| err | output | 1 | Last start carried an invalid size |

## Verification
The assertions assume that ready is a plain level that may drop in any cycle. They also assume that start is only honoured when the block is idle, so the hold and stepping properties depend only on the valid/ready pairing. The stimulus raises start for a single cycle at a time and changes sizeIn only together with start. It drives ready at falling edges, either held high or gated by a repeating stall pattern, so hold intervals appear in the middle of stages and at stage boundaries. Invalid sizes and a start issued during a running schedule are applied only in situations where the specified result is no output at all.

// File: rtl/fft_sched_pkg.sv
package fft_sched_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } schedCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } schedState_t;

endpackage

// File: rtl/fft_size_check.sv
module fft_size_check #(
  parameter int IDX_W = 6,
  localparam int SZ_W  = IDX_W + 1,
  localparam int LOG_W = $clog2(IDX_W + 1)
) (
  input  logic [SZ_W-1:0]  sizeIn,
  output logic             sizeOk,
  output logic             sizeBad,
  output logic [LOG_W-1:0] sizeLog
);

  logic isPow2;
  logic aboveOne;

  always_comb begin
    isPow2   = (sizeIn != '0) && ((sizeIn & (sizeIn - SZ_W'(1))) == '0);
    aboveOne = sizeIn > SZ_W'(1);
    sizeLog  = '0;
    for (int b = 0; b < SZ_W; b++) begin
      if (sizeIn[b]) sizeLog = LOG_W'(b);
    end
    sizeOk  = isPow2 && aboveOne;
    sizeBad = !isPow2 && aboveOne;
  end

endmodule

// File: rtl/fft_sched_ctrl.sv
module fft_sched_ctrl
  import fft_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      sizeOk,
  input  logic      sizeBad,
  input  logic      ready,
  input  logic      endOfAll,
  output schedCmd_t cmd,
  output logic      running,
  output logic      errFlag
);

  schedState_t state;

  always_comb begin
    cmd.load = (state == ST_IDLE) && start && sizeOk;
    cmd.step = (state == ST_RUN) && ready;
    running  = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            errFlag <= sizeBad;
            if (sizeOk) state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (ready && endOfAll) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fft_sched_dp.sv
module fft_sched_dp
  import fft_sched_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int SZ_W  = IDX_W + 1,
  localparam int LOG_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  schedCmd_t        cmd,
  input  logic [LOG_W-1:0] logIn,
  output logic [IDX_W-1:0] idxUpper,
  output logic [IDX_W-1:0] idxLower,
  output logic [IDX_W-1:0] twiddle,
  output logic [LOG_W-1:0] stageIdx,
  output logic             endOfStage,
  output logic             endOfAll
);

  logic [IDX_W-1:0] pairCnt;
  logic [LOG_W-1:0] stageCnt;
  logic [LOG_W-1:0] logN;

  logic [IDX_W-1:0] spanBit;
  logic [IDX_W-1:0] halfMask;
  logic [IDX_W-1:0] kOff;
  logic [LOG_W-1:0] twShift;
  logic [SZ_W-1:0]  fullSize;
  logic [IDX_W-1:0] pairsPerStage;

  always_comb begin
    spanBit       = IDX_W'(1) << stageCnt;
    halfMask      = spanBit - IDX_W'(1);
    kOff          = pairCnt & halfMask;
    // insert a zero at bit position stageCnt to form the group base
    idxUpper      = ((pairCnt & ~halfMask) << 1) | kOff;
    idxLower      = idxUpper | spanBit;
    twShift       = logN - LOG_W'(1) - stageCnt;
    twiddle       = kOff << twShift;
    fullSize      = SZ_W'(1) << logN;
    pairsPerStage = IDX_W'(fullSize >> 1);
    stageIdx      = stageCnt;
    endOfStage    = (pairCnt == pairsPerStage - IDX_W'(1));
    endOfAll      = endOfStage && (stageCnt == logN - LOG_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairCnt  <= '0;
      stageCnt <= '0;
      logN     <= '0;
    end else if (cmd.load) begin
      pairCnt  <= '0;
      stageCnt <= '0;
      logN     <= logIn;
    end else if (cmd.step) begin
      if (endOfStage) begin
        pairCnt  <= '0;
        stageCnt <= stageCnt + LOG_W'(1);
      end else begin
        pairCnt <= pairCnt + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/fft_bfly_sched.sv
module fft_bfly_sched
  import fft_sched_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int SZ_W  = IDX_W + 1,
  localparam int LOG_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SZ_W-1:0]  sizeIn,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] idxUpper,
  output logic [IDX_W-1:0] idxLower,
  output logic [IDX_W-1:0] twiddle,
  output logic [LOG_W-1:0] stageIdx,
  output logic             lastStage,
  output logic             lastAll,
  output logic             err
);

  schedCmd_t        cmd;
  logic             sizeOk;
  logic             sizeBad;
  logic [LOG_W-1:0] sizeLog;
  logic             running;
  logic             endOfStage;
  logic             endOfAll;

  fft_size_check #(.IDX_W(IDX_W)) u_size (
    .sizeIn (sizeIn),
    .sizeOk (sizeOk),
    .sizeBad(sizeBad),
    .sizeLog(sizeLog)
  );

  fft_sched_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .sizeOk  (sizeOk),
    .sizeBad (sizeBad),
    .ready   (ready),
    .endOfAll(endOfAll),
    .cmd     (cmd),
    .running (running),
    .errFlag (err)
  );

  fft_sched_dp #(.IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .logIn     (sizeLog),
    .idxUpper  (idxUpper),
    .idxLower  (idxLower),
    .twiddle   (twiddle),
    .stageIdx  (stageIdx),
    .endOfStage(endOfStage),
    .endOfAll  (endOfAll)
  );

  assign valid     = running;
  assign lastStage = running && endOfStage;
  assign lastAll   = running && endOfAll;

endmodule

// File: rtl/fft_bfly_sched_chk.sv
module fft_bfly_sched_chk #(
  parameter int IDX_W = 6,
  localparam int LOG_W = $clog2(IDX_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ready,
  input logic             valid,
  input logic [IDX_W-1:0] idxUpper,
  input logic [IDX_W-1:0] idxLower,
  input logic [IDX_W-1:0] twiddle,
  input logic [LOG_W-1:0] stageIdx,
  input logic             lastStage,
  input logic             lastAll,
  input logic             err
);

  p_lower_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (idxLower == idxUpper + (IDX_W'(1) << stageIdx)));

  p_upper_bit_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> ((idxUpper & (IDX_W'(1) << stageIdx)) == '0));

  p_tw_stage0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (valid && stageIdx == '0) |-> (twiddle == '0));

  p_step_in_stage_r5: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready && !lastStage) |=>
      (valid && stageIdx == $past(stageIdx) && idxUpper > $past(idxUpper)));

  p_next_stage_r5: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready && lastStage && !lastAll) |=>
      (valid && stageIdx == $past(stageIdx) + LOG_W'(1) && idxUpper == '0));

  p_last_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastAll |-> lastStage);

  p_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready && lastAll) |=> !valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !ready) |=>
      (valid && $stable(idxUpper) && $stable(idxLower) && $stable(twiddle)
       && $stable(stageIdx)));

  p_err_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !valid);

endmodule

bind fft_bfly_sched fft_bfly_sched_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .valid    (valid),
  .idxUpper (idxUpper),
  .idxLower (idxLower),
  .twiddle  (twiddle),
  .stageIdx (stageIdx),
  .lastStage(lastStage),
  .lastAll  (lastAll),
  .err      (err)
);

// File: tb/sim_fft_bfly_sched.sv
`timescale 1ns/1ps
module sim_fft_bfly_sched;

  localparam int IDX_W = 6;
  localparam int SZ_W  = IDX_W + 1;
  localparam int LOG_W = $clog2(IDX_W + 1);
  localparam int NVEC  = 12;

  // vector: [8] stall pattern, [7] expected error, [6:0] size
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 7'd2},  {1'b0, 1'b0, 7'd4},  {1'b1, 1'b0, 7'd8},
    {1'b0, 1'b0, 7'd16}, {1'b1, 1'b0, 7'd32}, {1'b0, 1'b0, 7'd64},
    {1'b0, 1'b1, 7'd3},  {1'b0, 1'b1, 7'd12}, {1'b0, 1'b0, 7'd0},
    {1'b0, 1'b0, 7'd1},  {1'b0, 1'b1, 7'd96}, {1'b1, 1'b0, 7'd64}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [SZ_W-1:0]  sizeIn = '0;
  logic             ready = 1'b0;
  logic             valid;
  logic [IDX_W-1:0] idxUpper, idxLower, twiddle;
  logic [LOG_W-1:0] stageIdx;
  logic             lastStage, lastAll, err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  fft_bfly_sched #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .sizeIn(sizeIn), .ready(ready),
    .valid(valid), .idxUpper(idxUpper), .idxLower(idxLower),
    .twiddle(twiddle), .stageIdx(stageIdx), .lastStage(lastStage),
    .lastAll(lastAll), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] packOut();
    return {7'd0, valid, err, idxUpper, idxLower, twiddle, stageIdx, lastStage, lastAll};
  endfunction

  task automatic runVec(input int sz, input bit expErr, input bit stall);
    bit pow;
    int lg;
    pow = (sz > 1) && ((sz & (sz - 1)) == 0);
    lg = 0;
    for (int b = 0; b < 7; b++) if (sz == (1 << b)) lg = b;
    @(negedge clk);
    start = 1'b1; sizeIn = SZ_W'(sz); ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (pow) begin
      for (int s = 0; s < lg; s++) begin
        for (int base = 0; base < sz; base += (2 << s)) begin
          for (int k = 0; k < (1 << s); k++) begin
            logic [31:0] expv;
            bit ls, la;
            ls = (k == (1 << s) - 1) && (base == sz - (2 << s));
            la = ls && (s == lg - 1);
            expv = {7'd0, 1'b1, 1'b0, 6'(base + k), 6'(base + k + (1 << s)),
                    6'(k * (sz / (2 << s))), 3'(s), ls, la};
            while (1) begin
              chk("R3 R4 R5 R6 R7 R10 butterfly", packOut(), expv);
              if (stall && (cyc % 3 == 0)) begin
                ready = 1'b0; cyc++; @(negedge clk);
              end else begin
                ready = 1'b1; cyc++; @(negedge clk);
                break;
              end
            end
          end
        end
      end
      ready = 1'b0;
      chk("R5 valid drops after schedule", {30'd0, valid, err}, 32'd0);
    end else if (expErr) begin
      chk("R1 bad size sets err, no valid", {30'd0, valid, err}, 32'd1);
    end else begin
      chk("R2 trivial size no output", {30'd0, valid, err}, 32'd0);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk("R9 reset state", {28'd0, valid, err, lastStage, lastAll}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      runVec(int'(VEC[v][6:0]), VEC[v][7], VEC[v][8]);
    end

    // R1: err clears on next accepted start
    runVec(5, 1'b1, 1'b0);
    @(negedge clk); start = 1'b1; sizeIn = 7'd4;
    @(negedge clk); start = 1'b0;
    chk("R1 err cleared by good start", {31'd0, err}, 32'd0);
    chk("R10 first butterfly", packOut(),
        {7'd0, 1'b1, 1'b0, 6'd0, 6'd1, 6'd0, 3'd0, 1'b0, 1'b0});
    ready = 1'b1; cnt = 0;
    while (valid) begin cnt++; @(negedge clk); end
    ready = 1'b0;
    chk("R5 count size 4", 32'(cnt), 32'd4);

    // R8: start during a run is ignored
    @(negedge clk); start = 1'b1; sizeIn = 7'd8;
    @(negedge clk); start = 1'b1; sizeIn = 7'd3; ready = 1'b1;
    @(negedge clk); start = 1'b1; sizeIn = 7'd4; ready = 1'b0;
    @(negedge clk); start = 1'b0;
    chk("R8 run unchanged after start while busy", packOut(),
        {7'd0, 1'b1, 1'b0, 6'd2, 6'd3, 6'd0, 3'd0, 1'b0, 1'b0});
    ready = 1'b1; cnt = 0;
    while (valid) begin cnt++; @(negedge clk); end
    ready = 1'b0;
    chk("R8 remaining butterflies of size 8", 32'(cnt), 32'd11);
    chk("R8 err untouched", {31'd0, err}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule